// File: doc/BRIEF.md
# Flash Timing Tick Divider with Debug Override

This block derives the slow timing base that paces flash erase and program steps. It divides the system clock down and emits a one-cycle clock enable at the divided rate. Because the output is an enable and not a new clock, every consumer stays in the system clock domain.

The 7-bit divide setting has two sources. Software writes it into a configuration register over the bus. A debug path can load its own 7-bit value, and while the lockout-recovery operation is active that debug value replaces the configuration value. The top bit of the setting turns on a fixed divide-by-8 prescaler. The low six bits give a count N, and the output period is 2×(N+1) prescaled steps. At 8 MHz, the setting 0x13 gives 200 kHz and 0x14 gives about 190 kHz. Software must choose a setting that lands in the 150–200 kHz window. The prescaler is meant only for fast input clocks; it must stay off below 12.8 MHz.

A status output tells whether the setting currently in use has been written since reset. Flash command requests are rejected while it is clear. Whenever the setting in use changes, or the source switches between the two registers, both counters restart. This prevents a shortened enable pulse.

Top module: `flash_tick_gen`

## Requirements
- R1: With setting bit 6 at 0, tickEn is high for exactly one cycle in every 2×(N+1) cycles, where N is setting bits 5:0.
- R2: With setting bit 6 at 1, the tick period is 16×(N+1) cycles.
- R3: While recoveryActive is 1, activeSetting equals the last value loaded through dbgLoadEn/dbgLoadData, and the tick period follows that value.
- R4: While recoveryActive is 0, the configuration register is in use. A debug load then changes neither activeSetting nor the tick period.
- R5: A configuration write made while recoveryActive is 1 leaves the tick period unchanged. The written value takes effect when recoveryActive returns to 0.
- R6: A change of activeSetting or a toggle of recoveryActive restarts both counters. The first tickEn then comes exactly period+1 rising edges after the write edge or after the toggle, and never earlier.
- R7: setValid is 1 when the register in use has been loaded since reset. That is the configuration register when recoveryActive is 0, and the debug register when it is 1.
- R8: In the same cycle as cmdReq, cmdGrant is high when setValid is 1, and cmdReject is high when setValid is 0.
- R9: A synchronous active-high reset clears both registers, both counters and both written flags. After reset, tickEn and setValid are 0 and activeSetting is 0.
- R10: The setting 0x13 gives a period of 40 cycles and 0x14 gives 42 cycles, which is 200 kHz and about 190 kHz from 8 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrEn | input | 1 | Bus write strobe for the configuration setting |
| cfgWrData | input | 7 | Configuration setting written on cfgWrEn |
| dbgLoadEn | input | 1 | Load strobe for the debug setting |
| dbgLoadData | input | 7 | Debug setting loaded on dbgLoadEn |
| recoveryActive | input | 1 | Lockout recovery in progress; selects the debug setting |
| cmdReq | input | 1 | Flash command request |
| cmdGrant | output | 1 | Request accepted (setting valid) |
| cmdReject | output | 1 | Request refused (setting not written) |
| setValid | output | 1 | Setting in use was written since reset |
| activeSetting | output | 7 | Setting currently in use |
| tickEn | output | 1 | One-cycle timing enable at the divided rate |

## Verification
The divider is tried with the two example settings, with a prescaled setting, and with a run of random settings drawn from the whole 7-bit range with a fixed seed. Together these separate errors in the ×2 factor, in the N+1 term and in the ×8 prescaler. For each setting, the bench measures the delay from the write edge to the first tick separately from the steady interval between ticks. A missing restart or a runt pulse therefore shows up apart from a wrong rate. Debug loads and configuration writes are each applied while the other source is in use, and recovery is toggled both with and without a prior debug load. This separates the source selection from the validity flag and from command gating.

// File: rtl/flash_tick_pkg.sv
package flash_tick_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;   // capture configuration setting
    logic loadDbg;   // capture debug setting
    logic clrCount;  // restart prescaler and divide counters
  } tickStrobe_t;

endpackage

// File: rtl/flash_tick_dp.sv
module flash_tick_dp
  import flash_tick_pkg::*;
#(
  parameter int SET_W     = 7,
  parameter int PRE_RATIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  tickStrobe_t      strobe,
  input  logic [SET_W-1:0] cfgWrData,
  input  logic [SET_W-1:0] dbgLoadData,
  input  logic             recoveryActive,
  output logic [SET_W-1:0] effSetting,
  output logic             tickEn
);
  localparam int DIV_W = SET_W - 1;
  localparam int CNT_W = DIV_W + 1;
  localparam int PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;

  logic [SET_W-1:0] cfgReg;
  logic [SET_W-1:0] dbgReg;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLimit;
  logic             preOn;
  logic             preEdge;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg <= '0;
      dbgReg <= '0;
    end else begin
      if (strobe.loadCfg) cfgReg <= cfgWrData;
      if (strobe.loadDbg) dbgReg <= dbgLoadData;
    end
  end

  assign effSetting = recoveryActive ? dbgReg : cfgReg;
  assign preOn      = effSetting[SET_W-1];
  // last count value of a 2*(N+1) cycle is 2N+1
  assign divLimit   = {effSetting[DIV_W-1:0], 1'b1};

  generate
    if (PRE_RATIO > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

      always_ff @(posedge clk) begin
        if (rst || strobe.clrCount || !preOn) preCnt <= '0;
        else if (preCnt == PRE_LAST)          preCnt <= '0;
        else                                  preCnt <= preCnt + 1'b1;
      end

      assign preEdge = !preOn || (preCnt == PRE_LAST);
    end else begin : g_nopre
      assign preEdge = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || strobe.clrCount) begin
      divCnt <= '0;
    end else if (preEdge) begin
      if (divCnt == divLimit) divCnt <= '0;
      else                    divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tickEn <= 1'b0;
    else     tickEn <= !strobe.clrCount && preEdge && (divCnt == divLimit);
  end

endmodule

// File: rtl/flash_tick_ctrl.sv
module flash_tick_ctrl
  import flash_tick_pkg::*;
#(
  parameter int SET_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWrEn,
  input  logic             dbgLoadEn,
  input  logic             recoveryActive,
  input  logic [SET_W-1:0] effSetting,
  input  logic             cmdReq,
  output tickStrobe_t      strobe,
  output logic             setValid,
  output logic             cmdGrant,
  output logic             cmdReject
);
  logic [SET_W-1:0] prevSetting;
  logic             prevSrc;
  logic             cfgSeen;
  logic             dbgSeen;
  logic             restart;

  assign restart = (effSetting != prevSetting) || (recoveryActive != prevSrc);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevSetting <= '0;
      prevSrc     <= 1'b0;
      cfgSeen     <= 1'b0;
      dbgSeen     <= 1'b0;
    end else begin
      prevSetting <= effSetting;
      prevSrc     <= recoveryActive;
      if (cfgWrEn)   cfgSeen <= 1'b1;
      if (dbgLoadEn) dbgSeen <= 1'b1;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadCfg  = cfgWrEn;
    strobe.loadDbg  = dbgLoadEn;
    strobe.clrCount = restart;
  end

  assign setValid  = recoveryActive ? dbgSeen : cfgSeen;
  assign cmdGrant  = cmdReq && setValid;
  assign cmdReject = cmdReq && !setValid;

endmodule

// File: rtl/flash_tick_gen.sv
module flash_tick_gen
  import flash_tick_pkg::*;
#(
  parameter int SET_W     = 7,
  parameter int PRE_RATIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWrEn,
  input  logic [SET_W-1:0] cfgWrData,
  input  logic             dbgLoadEn,
  input  logic [SET_W-1:0] dbgLoadData,
  input  logic             recoveryActive,
  input  logic             cmdReq,
  output logic             cmdGrant,
  output logic             cmdReject,
  output logic             setValid,
  output logic [SET_W-1:0] activeSetting,
  output logic             tickEn
);
  tickStrobe_t strobe;

  flash_tick_ctrl #(.SET_W(SET_W)) i_ctrl (
    .clk, .rst, .cfgWrEn, .dbgLoadEn, .recoveryActive,
    .effSetting(activeSetting), .cmdReq,
    .strobe, .setValid, .cmdGrant, .cmdReject
  );

  flash_tick_dp #(.SET_W(SET_W), .PRE_RATIO(PRE_RATIO)) i_dp (
    .clk, .rst, .strobe, .cfgWrData, .dbgLoadData, .recoveryActive,
    .effSetting(activeSetting), .tickEn
  );

endmodule

// File: rtl/flash_tick_chk.sv
module flash_tick_chk #(
  parameter int SET_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             cfgWrEn,
  input logic [SET_W-1:0] cfgWrData,
  input logic             dbgLoadEn,
  input logic [SET_W-1:0] dbgLoadData,
  input logic             recoveryActive,
  input logic             cmdReq,
  input logic             cmdGrant,
  input logic             cmdReject,
  input logic             setValid,
  input logic [SET_W-1:0] activeSetting,
  input logic             tickEn
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tickEn |=> !tickEn); // R1

  AST_DBG_SELECT: assert property (@(posedge clk) disable iff (rst)
    dbgLoadEn && recoveryActive |=> (!recoveryActive || activeSetting == $past(dbgLoadData))); // R3

  AST_CFG_SELECT: assert property (@(posedge clk) disable iff (rst)
    cfgWrEn && !recoveryActive |=> (recoveryActive || activeSetting == $past(cfgWrData))); // R4

  AST_SWITCH_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
    !$stable(recoveryActive) |=> !tickEn); // R6

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    setValid |=> (setValid || recoveryActive != $past(recoveryActive))); // R7

  AST_CMD_GATE: assert property (@(posedge clk) disable iff (rst)
    cmdReq |-> (cmdGrant == setValid) && (cmdReject == !setValid)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !tickEn && !setValid && activeSetting == '0); // R9
endmodule

bind flash_tick_gen flash_tick_chk #(.SET_W(SET_W)) i_chk (.*);

// File: tb/test_flash_tick_gen.sv
module test_flash_tick_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfgWrEn, dbgLoadEn, recoveryActive, cmdReq;
  logic [6:0] cfgWrData, dbgLoadData;
  logic       cmdGrant, cmdReject, setValid, tickEn;
  logic [6:0] activeSetting;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 125 MHz

  flash_tick_gen i_flash_tick_gen (
    .clk, .rst, .cfgWrEn, .cfgWrData, .dbgLoadEn, .dbgLoadData,
    .recoveryActive, .cmdReq, .cmdGrant, .cmdReject, .setValid,
    .activeSetting, .tickEn
  );

  function automatic int periodOf(input logic [6:0] s);
    return (s[6] ? 16 : 2) * (int'(s[5:0]) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count rising edges until tickEn is seen high (sampled at negedge)
  task automatic edgesToTick(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
    end while (!tickEn && n < 5000);
  endtask

  task automatic waitTick();
    int n;
    edgesToTick(n);
  endtask

  task automatic writeCfg(input logic [6:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic loadDbg(input logic [6:0] v);
    dbgLoadEn = 1'b1; dbgLoadData = v;
    @(posedge clk); @(negedge clk);
    dbgLoadEn = 1'b0;
  endtask

  // write at edge E0 and check first-tick delay and steady interval
  task automatic writeAndMeasure(input logic [6:0] v, input string req);
    int n;
    int p;
    p = periodOf(v);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0;
    edgesToTick(n);
    check(n == p + 1, {req, " first tick"}, n, p + 1);
    edgesToTick(n);
    check(n == p, {req, " period"}, n, p);
  endtask

  task automatic cmdProbe(input bit expGrant, input string req);
    cmdReq = 1'b1; #1;
    check(cmdGrant == expGrant && cmdReject == !expGrant, req, int'(cmdGrant), int'(expGrant));
    cmdReq = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    int p;
    logic [6:0] cur;
    logic [6:0] nxt;
    void'($urandom(32'd1234));
    rst = 1'b1; cfgWrEn = 0; dbgLoadEn = 0; recoveryActive = 0; cmdReq = 0;
    cfgWrData = '0; dbgLoadData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R9: reset state
    check(tickEn == 1'b0, "R9 tickEn", int'(tickEn), 0);
    check(setValid == 1'b0, "R9 setValid", int'(setValid), 0);
    check(activeSetting == 7'h00, "R9 activeSetting", int'(activeSetting), 0);
    cmdProbe(1'b0, "R8 reject before write");

    // R10 / R1 / R6: example settings
    writeAndMeasure(7'h13, "R10 0x13");
    check(setValid == 1'b1, "R7 valid after cfg write", int'(setValid), 1);
    cmdProbe(1'b1, "R8 grant after write");
    writeAndMeasure(7'h14, "R10 0x14");

    // R7: recovery with no debug load yet -> not valid
    recoveryActive = 1'b1; #1;
    check(setValid == 1'b0, "R7 recovery without debug load", int'(setValid), 0);
    cmdProbe(1'b0, "R8 reject in recovery unloaded");
    @(negedge clk); recoveryActive = 1'b0;
    waitTick();

    // R2: prescaler on
    writeAndMeasure(7'h45, "R2 prescaled");

    // R4: debug load outside recovery has no effect
    waitTick();
    loadDbg(7'h02);
    check(activeSetting == 7'h45, "R4 activeSetting", int'(activeSetting), 'h45);
    edgesToTick(n);
    check(n == periodOf(7'h45) - 1, "R4 period kept", n, periodOf(7'h45) - 1);

    // R3 / R6: enter recovery, debug value takes over
    recoveryActive = 1'b1; #1;
    check(activeSetting == 7'h02, "R3 activeSetting", int'(activeSetting), 2);
    check(setValid == 1'b1, "R7 valid with debug load", int'(setValid), 1);
    @(negedge clk);
    // the toggle-side clearing edge was the edge just passed
    edgesToTick(n);
    check(n == periodOf(7'h02), "R6 first tick after switch", n, periodOf(7'h02));
    edgesToTick(n);
    check(n == periodOf(7'h02), "R3 period", n, periodOf(7'h02));

    // R5: config write during recovery does not disturb tick
    writeCfg(7'h20);
    edgesToTick(n);
    check(n == periodOf(7'h02) - 1, "R5 period kept", n, periodOf(7'h02) - 1);
    check(activeSetting == 7'h02, "R5 activeSetting", int'(activeSetting), 2);

    // R5 / R6: leave recovery, new cfg value applies
    recoveryActive = 1'b0;
    edgesToTick(n);
    check(n == periodOf(7'h20) + 1, "R6 first tick after exit", n, periodOf(7'h20) + 1);
    edgesToTick(n);
    check(n == periodOf(7'h20), "R5 new period", n, periodOf(7'h20));

    // R1 / R2 / R6: random settings
    cur = 7'h20;
    for (int i = 0; i < 14; i++) begin
      nxt = 7'($urandom);
      if (nxt == cur) nxt = nxt ^ 7'h01;
      writeAndMeasure(nxt, nxt[6] ? "R2 random" : "R1 random");
      cur = nxt;
    end

    // R9: reset again mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check(setValid == 1'b0 && activeSetting == 7'h00, "R9 second reset",
          int'(activeSetting), 0);
    p = periodOf(7'h00);
    edgesToTick(n);
    check(n == p, "R9 counters cleared", n, p);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule